// File: doc/BRIEF.md
# IDE Channel Port Access Decoder

This block sits between a host I/O path and the register set of one IDE channel. The host side presents accesses to two small windows: an eight-byte window holding the data port and the task-file registers, and a four-byte control window holding the alternate-status/device-control register. Each access carries an offset, a byte count of 1, 2 or 4, a read/write flag and write data. The block decides whether the access is legal and routes each legal access to a drive-register interface. It does this through a register select, data-port strobes and a width qualifier. It returns read data one cycle after the access is accepted.

Whether an access is legal depends on both the offset and the width. Single bytes reach every task-file offset. Two-byte and four-byte transfers reach only the data port at offset 0. The control window passes one single-byte location and nothing else. Illegal writes are absorbed without touching the drive side. Illegal reads complete at once and return a float pattern of all ones at the access width. The drive side may stall legal accesses with a ready signal.

Top module: `ide_port_decoder`

## Requirements
- R1: While reset is low, host_ready and host_rsp_valid are 0 and drv_req is 0, whatever the host presents.
- R2: A control-window access (host_ctrl_win=1) of size 1 at offset 2 is forwarded with drv_sel_ctrl=1 and drv_reg_off=2. A write of it changes the drive-side control register. A read of it returns that register's byte in bits [7:0].
- R3: Any other control-window access is not forwarded (drv_req stays 0). This covers offsets 0, 1, 3 and offsets of 4 or more, and sizes 2 and 4 at any offset. Such a write leaves the drive-side registers unchanged. Such a read returns ones in the low 8, 16 or 32 bits for size 1, 2 or 4, with zeros above.
- R4: A data-window access (host_ctrl_win=0) of size 1 is forwarded at any offset 0..7 as a task-file byte access, with drv_sel_ctrl=0, drv_data_port=0 and drv_reg_off equal to the offset.
- R5: A data-window access at offset 0 of size 2 is a data-port transfer with drv_data_port=1 and drv_width32=0. The same access with size 4 is a data-port transfer with drv_width32=1.
- R6: A data-window access of size 2 or 4 at a non-zero offset is not forwarded. Its write leaves the drive side unchanged. Its read returns all ones in the low 16 or 32 bits.
- R7: A size code other than 1, 2 or 4 (0, 3, 5, 6 or 7) is never forwarded. Its write is ignored. Its read returns all 32 bits set.
- R8: Data is little-endian. The first byte is in bits [7:0] of host_wdata, drv_wdata and host_rsp_data, and the following bytes are in the next lanes. Lanes beyond the access width are zero on drv_wdata and on the returned read data.
- R9: Each accepted data-port read raises drv_data_rd_stb for exactly one cycle, and each accepted data-port write raises drv_data_wr_stb for exactly one cycle.
- R10: A forwarded access holds host_ready low until drv_ready is 1 and is accepted in that cycle. An access that is not forwarded is accepted in the cycle it is presented. host_rsp_valid is 1 exactly in the cycle after an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Host access request |
| host_ready | output | 1 | Access accepted this cycle when high together with host_valid |
| host_ctrl_win | input | 1 | 1 selects the control window, 0 selects the data/task-file window |
| host_off | input | OFF_W (3) | Byte offset inside the selected window |
| host_size | input | SIZE_W (3) | Access size in bytes; legal values 1, 2, 4 |
| host_wr | input | 1 | 1 for write, 0 for read |
| host_wdata | input | DATA_W (32) | Write data, little-endian |
| host_rsp_valid | output | 1 | Read data valid, one cycle after an accepted read |
| host_rsp_data | output | DATA_W (32) | Read data or float pattern |
| drv_req | output | 1 | Forwarded access toward the drive registers |
| drv_ready | input | 1 | Drive side can complete the forwarded access this cycle |
| drv_we | output | 1 | Forwarded access is a write |
| drv_sel_ctrl | output | 1 | 1 selects the alternate-status/device-control register |
| drv_reg_off | output | OFF_W (3) | Register offset on the drive side |
| drv_data_port | output | 1 | Forwarded access is a data-port transfer |
| drv_width32 | output | 1 | Data-port transfer is 32 bits wide (0 means 16 bits) |
| drv_data_rd_stb | output | 1 | One-cycle pulse per accepted data-port read |
| drv_data_wr_stb | output | 1 | One-cycle pulse per accepted data-port write |
| drv_wdata | output | DATA_W (32) | Write data with unused lanes cleared |
| drv_rdata | input | DATA_W (32) | Read data from the drive side, valid during the accepting cycle |

## Verification
The bench builds the block with its defaults: 32-bit data, a three-bit offset and a three-bit size code. These values make the 32-bit data-port transfer reachable. Every offset of both windows can be addressed, including control-window offsets beyond its four bytes. The size code can carry the illegal encodings 0, 3, 5, 6 and 7. The drive stub returns junk in the upper lanes and can stall for a chosen number of cycles. This exposes lane clearing, the float widths, the handshake wait and the single strobe per stalled data-port read.

// File: rtl/ide_dec_pkg.sv
// Shared types for the IDE channel port access decoder.
// Assumes nothing beyond the route encoding being private to this block.
package ide_dec_pkg;

    // Where a host access goes after legality checking.
    typedef enum logic [1:0] {
        ACC_DROP      = 2'd0,  // illegal: absorbed on write, float on read
        ACC_TF_BYTE   = 2'd1,  // single byte to a task-file register
        ACC_CTRL_BYTE = 2'd2,  // single byte to alternate-status/device-control
        ACC_DATA_PORT = 2'd3   // 16- or 32-bit data-port transfer
    } acc_route_e;

endpackage

// File: rtl/ide_dec_classify.sv
// Access classifier: decides from window, offset and size whether an access
// is legal and where it goes, and builds the byte-lane mask of its width.
// Assumes DATA_W is a multiple of 8 and OFF_W is larger than CTRL_OFF_W.
module ide_dec_classify
    import ide_dec_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int OFF_W        = 3,
    parameter int CTRL_OFF_W   = 2,
    parameter int CTRL_REG_OFF = 2,
    parameter int SIZE_W       = 3
) (
    input  logic              ctrl_win,
    input  logic [OFF_W-1:0]  off,
    input  logic [SIZE_W-1:0] size,
    output acc_route_e        route,
    output logic              wide32,
    output logic [DATA_W-1:0] lane_mask
);
    localparam int LANES = DATA_W / 8;

    logic size_ok;
    logic ctrl_hit;

    // Purpose: flag the size codes the block understands.
    always_comb begin
        size_ok = (size == SIZE_W'(1)) || (size == SIZE_W'(2)) ||
                  ((size == SIZE_W'(4)) && (LANES >= 4));
    end

    // Purpose: locate the single legal byte inside the control window.
    always_comb begin
        ctrl_hit = (off[CTRL_OFF_W-1:0] == CTRL_OFF_W'(CTRL_REG_OFF)) &&
                   (off[OFF_W-1:CTRL_OFF_W] == '0);
    end

    // Purpose: choose the route of the access.
    always_comb begin
        route = ACC_DROP;
        if (ctrl_win) begin
            if ((size == SIZE_W'(1)) && ctrl_hit) begin
                route = ACC_CTRL_BYTE;
            end
        end else if (size == SIZE_W'(1)) begin
            route = ACC_TF_BYTE;
        end else if (size_ok && (off == '0)) begin
            route = ACC_DATA_PORT;
        end
    end

    // Purpose: qualify a data-port transfer as full 32 bits wide.
    always_comb begin
        wide32 = (size == SIZE_W'(4));
    end

    // One byte-lane enable per lane; an unknown size enables every lane.
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign lane_mask[b*8 +: 8] = {8{!size_ok || (b < int'(size))}};
    end

endmodule

// File: rtl/ide_dec_drive_side.sv
// Drive-side request generator: forwards legal accesses with register select,
// width qualifier and data-port strobes, and runs the host handshake.
// Assumes drv_ready may depend on drv_req but not on host_ready.
module ide_dec_drive_side
    import ide_dec_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int OFF_W        = 3,
    parameter int CTRL_REG_OFF = 2
) (
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic              host_wr,
    input  logic [OFF_W-1:0]  host_off,
    input  logic [DATA_W-1:0] host_wdata,
    input  acc_route_e        route,
    input  logic              wide32,
    input  logic [DATA_W-1:0] lane_mask,
    input  logic              drv_ready,
    output logic              host_ready,
    output logic              accept,
    output logic              drv_req,
    output logic              drv_we,
    output logic              drv_sel_ctrl,
    output logic [OFF_W-1:0]  drv_reg_off,
    output logic              drv_data_port,
    output logic              drv_width32,
    output logic              drv_data_rd_stb,
    output logic              drv_data_wr_stb,
    output logic [DATA_W-1:0] drv_wdata
);
    logic forward;

    // Purpose: forwarded accesses wait for the drive; dropped ones never do.
    always_comb begin
        forward    = (route != ACC_DROP);
        drv_req    = rst_n && host_valid && forward;
        host_ready = rst_n && (forward ? drv_ready : 1'b1);
        accept     = host_valid && host_ready;
    end

    // Purpose: register select and width qualifiers toward the drive.
    always_comb begin
        drv_we        = host_wr;
        drv_sel_ctrl  = (route == ACC_CTRL_BYTE);
        drv_data_port = (route == ACC_DATA_PORT);
        drv_width32   = drv_data_port && wide32;
        drv_reg_off   = drv_sel_ctrl ? OFF_W'(CTRL_REG_OFF) : host_off;
    end

    // Purpose: one strobe per completed data-port transfer.
    always_comb begin
        drv_data_rd_stb = drv_req && drv_ready && drv_data_port && !host_wr;
        drv_data_wr_stb = drv_req && drv_ready && drv_data_port && host_wr;
    end

    // Purpose: clear write lanes beyond the access width.
    always_comb begin
        drv_wdata = host_wdata & lane_mask;
    end

endmodule

// File: rtl/ide_dec_resp.sv
// Read response register: captures drive read data, or the float pattern for
// dropped reads, in the cycle a read is accepted.
// Assumes drv_rdata is valid in the accepting cycle.
module ide_dec_resp
    import ide_dec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              host_wr,
    input  acc_route_e        route,
    input  logic [DATA_W-1:0] lane_mask,
    input  logic [DATA_W-1:0] drv_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    logic              take;
    logic [DATA_W-1:0] next_data;

    // Purpose: pick drive data or float ones, trimmed to the access width.
    always_comb begin
        take      = accept && !host_wr;
        next_data = (route == ACC_DROP) ? lane_mask : (drv_rdata & lane_mask);
    end

    // Purpose: present the read result one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= take;
            if (take) begin
                rsp_data <= next_data;
            end
        end
    end

endmodule

// File: rtl/ide_port_decoder.sv
// Top of the IDE channel port access decoder: classifies host accesses to the
// data/task-file and control windows, forwards legal ones to the drive
// registers and returns read data or a float pattern.
// Assumes one outstanding access at a time and DATA_W of at least 32.
module ide_port_decoder
    import ide_dec_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int OFF_W        = 3,
    parameter int CTRL_OFF_W   = 2,
    parameter int CTRL_REG_OFF = 2,
    parameter int SIZE_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    output logic              host_ready,
    input  logic              host_ctrl_win,
    input  logic [OFF_W-1:0]  host_off,
    input  logic [SIZE_W-1:0] host_size,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_rsp_valid,
    output logic [DATA_W-1:0] host_rsp_data,
    output logic              drv_req,
    input  logic              drv_ready,
    output logic              drv_we,
    output logic              drv_sel_ctrl,
    output logic [OFF_W-1:0]  drv_reg_off,
    output logic              drv_data_port,
    output logic              drv_width32,
    output logic              drv_data_rd_stb,
    output logic              drv_data_wr_stb,
    output logic [DATA_W-1:0] drv_wdata,
    input  logic [DATA_W-1:0] drv_rdata
);
    acc_route_e        route;
    logic              wide32;
    logic [DATA_W-1:0] lane_mask;
    logic              accept;

    ide_dec_classify #(
        .DATA_W      (DATA_W),
        .OFF_W       (OFF_W),
        .CTRL_OFF_W  (CTRL_OFF_W),
        .CTRL_REG_OFF(CTRL_REG_OFF),
        .SIZE_W      (SIZE_W)
    ) u_classify (
        .ctrl_win (host_ctrl_win),
        .off      (host_off),
        .size     (host_size),
        .route    (route),
        .wide32   (wide32),
        .lane_mask(lane_mask)
    );

    ide_dec_drive_side #(
        .DATA_W      (DATA_W),
        .OFF_W       (OFF_W),
        .CTRL_REG_OFF(CTRL_REG_OFF)
    ) u_drive (
        .rst_n          (rst_n),
        .host_valid     (host_valid),
        .host_wr        (host_wr),
        .host_off       (host_off),
        .host_wdata     (host_wdata),
        .route          (route),
        .wide32         (wide32),
        .lane_mask      (lane_mask),
        .drv_ready      (drv_ready),
        .host_ready     (host_ready),
        .accept         (accept),
        .drv_req        (drv_req),
        .drv_we         (drv_we),
        .drv_sel_ctrl   (drv_sel_ctrl),
        .drv_reg_off    (drv_reg_off),
        .drv_data_port  (drv_data_port),
        .drv_width32    (drv_width32),
        .drv_data_rd_stb(drv_data_rd_stb),
        .drv_data_wr_stb(drv_data_wr_stb),
        .drv_wdata      (drv_wdata)
    );

    ide_dec_resp #(
        .DATA_W(DATA_W)
    ) u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .host_wr  (host_wr),
        .route    (route),
        .lane_mask(lane_mask),
        .drv_rdata(drv_rdata),
        .rsp_valid(host_rsp_valid),
        .rsp_data (host_rsp_data)
    );

endmodule

// File: rtl/ide_port_decoder_chk.sv
// Property checker for the IDE channel port access decoder, bound to the top.
// Assumes the same parameter values as the instance it is bound to.
module ide_port_decoder_chk #(
    parameter int DATA_W       = 32,
    parameter int OFF_W        = 3,
    parameter int CTRL_REG_OFF = 2,
    parameter int SIZE_W       = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_valid,
    input logic              host_ready,
    input logic              host_ctrl_win,
    input logic [OFF_W-1:0]  host_off,
    input logic [SIZE_W-1:0] host_size,
    input logic              host_wr,
    input logic              host_rsp_valid,
    input logic              drv_req,
    input logic              drv_ready,
    input logic              drv_we,
    input logic              drv_sel_ctrl,
    input logic              drv_data_port,
    input logic              drv_data_rd_stb,
    input logic              drv_data_wr_stb,
    input logic [DATA_W-1:0] drv_wdata
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !host_rsp_valid);                                           // R1

    AST_RESET_NO_REQ: assert property (@(posedge clk)
        !rst_n |-> (!drv_req && !host_ready));                                 // R1

    AST_CTRL_ONLY_BYTE2: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_req && drv_sel_ctrl) |->
        (host_ctrl_win && host_size == SIZE_W'(1) && host_off == OFF_W'(CTRL_REG_OFF))); // R3

    AST_WIDE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_req && drv_data_port) |-> (host_off == '0 && !host_ctrl_win));    // R6

    AST_BAD_SIZE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_size != SIZE_W'(1) && host_size != SIZE_W'(2) &&
         host_size != SIZE_W'(4)) |-> !drv_req);                              // R7

    AST_BYTE_LANES_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_req && drv_we && host_size == SIZE_W'(1)) |-> (drv_wdata[DATA_W-1:8] == '0)); // R8

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drv_data_rd_stb, drv_data_wr_stb}));                         // R9

    AST_STROBE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_data_rd_stb || drv_data_wr_stb) |-> (drv_req && drv_ready));      // R9

    AST_DROP_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !drv_req) |-> host_ready);                              // R10

    AST_READ_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready && !host_wr) |=> host_rsp_valid);            // R10

    AST_RSP_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        host_rsp_valid |-> $past(host_valid && host_ready && !host_wr));       // R10

endmodule

bind ide_port_decoder ide_port_decoder_chk #(
    .DATA_W      (DATA_W),
    .OFF_W       (OFF_W),
    .CTRL_REG_OFF(CTRL_REG_OFF),
    .SIZE_W      (SIZE_W)
) u_chk (.*);

// File: tb/ide_port_decoder_bench.sv
// Directed bench for the IDE channel port access decoder with a stub drive.
module ide_port_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_ready;
    logic        host_ctrl_win = 1'b0;
    logic [2:0]  host_off = '0;
    logic [2:0]  host_size = 3'd1;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        host_rsp_valid;
    logic [31:0] host_rsp_data;
    logic        drv_req, drv_ready, drv_we, drv_sel_ctrl, drv_data_port, drv_width32;
    logic [2:0]  drv_reg_off;
    logic        drv_data_rd_stb, drv_data_wr_stb;
    logic [31:0] drv_wdata, drv_rdata;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    ide_port_decoder u_ide_port_decoder (.*);

    // Stub drive: byte registers, a control byte, a data-port word source.
    logic [7:0]  tf [8];
    logic [7:0]  ctl_reg;
    logic [31:0] last_dw;
    int          rd_idx, wr_seen, stall_left, rd_pulses;

    function automatic logic [31:0] fifo_word(int i);
        return 32'h8C4F_1E00 + 32'(i);
    endfunction

    assign drv_ready = (stall_left == 0);
    always_comb begin
        if (drv_data_port)     drv_rdata = fifo_word(rd_idx);
        else if (drv_sel_ctrl) drv_rdata = {24'hEEEEEE, ctl_reg};
        else                   drv_rdata = {24'hEEEEEE, tf[drv_reg_off]};
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) tf[i] <= 8'h10 + 8'(i);
            ctl_reg <= 8'h5A;
            last_dw <= '0;
            rd_idx  <= 0;
            wr_seen <= 0;
        end else begin
            if (drv_req && stall_left > 0) stall_left <= stall_left - 1;
            if (drv_data_rd_stb) begin
                rd_idx    <= rd_idx + 1;
                rd_pulses <= rd_pulses + 1;
            end
            if (drv_req && drv_ready && drv_we) begin
                wr_seen <= wr_seen + 1;
                if (drv_data_port)     last_dw <= drv_wdata;
                else if (drv_sel_ctrl) ctl_reg <= drv_wdata[7:0];
                else                   tf[drv_reg_off] <= drv_wdata[7:0];
            end
        end
    end

    // Values captured from the drive interface in the accepting cycle.
    logic        cap_req, cap_ctrl, cap_dp, cap_w32;
    logic [2:0]  cap_off;
    logic [31:0] cap_wd, rsp;
    logic        rsp_v;
    int          waits;
    int          exp_idx = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(bit cw, logic [2:0] off, logic [2:0] sz, bit wr, logic [31:0] wd);
        @(negedge clk);
        host_ctrl_win = cw; host_off = off; host_size = sz;
        host_wr = wr; host_wdata = wd; host_valid = 1'b1;
        waits = 0;
        forever begin
            #5;
            cap_req = drv_req; cap_ctrl = drv_sel_ctrl; cap_off = drv_reg_off;
            cap_dp = drv_data_port; cap_w32 = drv_width32; cap_wd = drv_wdata;
            if (host_ready) break;
            waits++;
            @(negedge clk);
        end
        @(negedge clk);
        host_valid = 1'b0;
        rsp_v = host_rsp_valid;
        rsp   = host_rsp_data;
    endtask

    task automatic t_reset();
        @(negedge clk);
        host_valid = 1'b1; host_ctrl_win = 1'b1; host_size = 3'd1; host_off = 3'd0;
        #5;
        check("R1 host_ready in reset", 32'(host_ready), 0);
        check("R1 drv_req in reset", 32'(drv_req), 0);
        check("R1 rsp_valid in reset", 32'(host_rsp_valid), 0);
        @(negedge clk);
        host_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_taskfile();
        access(0, 3'd5, 3'd1, 1, 32'hAABB_CC3C);
        check("R4 tf write forwarded", 32'(cap_req), 1);
        check("R4 tf offset", 32'(cap_off), 5);
        check("R4 tf not data port", 32'({cap_ctrl, cap_dp}), 0);
        check("R8 byte write lanes", cap_wd, 32'h0000_003C);
        access(0, 3'd5, 3'd1, 0, 0);
        check("R10 rsp valid after read", 32'(rsp_v), 1);
        check("R4 tf read back", rsp, 32'h3C);
        access(0, 3'd7, 3'd1, 0, 0);
        check("R4 tf read offset 7", rsp, 32'h17);
    endtask

    task automatic t_control();
        access(1, 3'd2, 3'd1, 1, 32'h0000_0008);
        check("R2 ctrl forwarded", 32'({cap_req, cap_ctrl, cap_off}), 32'b1_1_010);
        check("R2 ctrl reg written", 32'(ctl_reg), 32'h08);
        access(1, 3'd2, 3'd1, 0, 0);
        check("R2 ctrl read", rsp, 32'h08);
    endtask

    task automatic t_control_illegal();
        int w0;
        w0 = wr_seen;
        access(1, 3'd0, 3'd1, 1, 32'hFF);
        check("R3 ctrl off0 write dropped", 32'(cap_req), 0);
        access(1, 3'd2, 3'd2, 1, 32'hFFFF);
        check("R3 ctrl size2 write dropped", 32'(cap_req), 0);
        access(1, 3'd6, 3'd1, 1, 32'hFF);
        check("R3 ctrl beyond window dropped", 32'(cap_req), 0);
        check("R3 no drive writes", 32'(wr_seen - w0), 0);
        access(1, 3'd1, 3'd1, 0, 0);
        check("R3 float byte", rsp, 32'h0000_00FF);
        access(1, 3'd2, 3'd2, 0, 0);
        check("R3 float half", rsp, 32'h0000_FFFF);
        access(1, 3'd0, 3'd4, 0, 0);
        check("R3 float word", rsp, 32'hFFFF_FFFF);
        access(1, 3'd2, 3'd1, 0, 0);
        check("R3 ctrl reg unchanged", rsp, 32'h08);
    endtask

    task automatic t_data_port();
        int p0;
        access(0, 3'd0, 3'd2, 1, 32'hDEAD_BEEF);
        check("R5 16-bit write qualifiers", 32'({cap_dp, cap_w32}), 32'b10);
        check("R8 16-bit write lanes", last_dw, 32'h0000_BEEF);
        access(0, 3'd0, 3'd4, 1, 32'h1234_5678);
        check("R5 32-bit write qualifiers", 32'({cap_dp, cap_w32}), 32'b11);
        check("R8 32-bit write data", last_dw, 32'h1234_5678);
        p0 = rd_pulses;
        access(0, 3'd0, 3'd2, 0, 0);
        check("R8 16-bit read lanes", rsp, fifo_word(exp_idx) & 32'h0000_FFFF);
        exp_idx++;
        check("R9 one pulse per 16-bit read", 32'(rd_pulses - p0), 1);
        access(0, 3'd0, 3'd4, 0, 0);
        check("R5 32-bit read", rsp, fifo_word(exp_idx));
        exp_idx++;
        check("R9 one pulse per 32-bit read", 32'(rd_pulses - p0), 2);
    endtask

    task automatic t_wide_offset();
        int w0;
        w0 = wr_seen;
        access(0, 3'd2, 3'd2, 1, 32'h0000_9999);
        check("R6 wide write at off2 dropped", 32'(cap_req), 0);
        check("R6 no drive write", 32'(wr_seen - w0), 0);
        access(0, 3'd2, 3'd1, 0, 0);
        check("R6 tf2 untouched", rsp, 32'h12);
        access(0, 3'd4, 3'd4, 0, 0);
        check("R6 float word at off4", rsp, 32'hFFFF_FFFF);
        access(0, 3'd6, 3'd2, 0, 0);
        check("R6 float half at off6", rsp, 32'h0000_FFFF);
    endtask

    task automatic t_bad_size();
        int w0;
        w0 = wr_seen;
        access(0, 3'd0, 3'd3, 1, 32'h7777_7777);
        check("R7 size3 write dropped", 32'(cap_req), 0);
        access(0, 3'd0, 3'd0, 1, 32'h7777_7777);
        check("R7 no drive write", 32'(wr_seen - w0), 0);
        access(0, 3'd0, 3'd5, 0, 0);
        check("R7 size5 float", rsp, 32'hFFFF_FFFF);
        access(0, 3'd0, 3'd7, 0, 0);
        check("R7 size7 float", rsp, 32'hFFFF_FFFF);
    endtask

    task automatic t_stall();
        int p0;
        stall_left = 3;
        access(0, 3'd1, 3'd1, 0, 0);
        check("R10 stalled wait cycles", 32'(waits), 3);
        check("R10 stalled read data", rsp, 32'h11);
        stall_left = 2;
        access(1, 3'd3, 3'd1, 0, 0);
        check("R10 dropped access no wait", 32'(waits), 0);
        check("R10 dropped read float", rsp, 32'hFF);
        stall_left = 2;
        p0 = rd_pulses;
        access(0, 3'd0, 3'd4, 0, 0);
        check("R9 single pulse on stalled read", 32'(rd_pulses - p0), 1);
        check("R9 stalled data word", rsp, fifo_word(exp_idx));
        exp_idx++;
        stall_left = 0;
    endtask

    initial begin
        stall_left = 0;
        rd_pulses  = 0;
        repeat (3) @(negedge clk);
        t_reset();
        repeat (2) @(negedge clk);
        t_taskfile();
        t_control();
        t_control_illegal();
        t_data_port();
        t_wide_offset();
        t_bad_size();
        t_stall();
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule